// File: doc/BRIEF.md
# Smart Card Power-Up / Power-Down Sequencer

This block steps a contact smart card through a timed power-up and a timed power-down, and tells a host controller about card status over one active-low interrupt line. The host opens a session with a falling edge on an active-low session command. The block then switches on the card supply, checks it, opens the I/O lines for reception and starts the card clock. The card reset follows the host's reset request only after a fixed number of card clock periods. Power-down happens when the host drops the session, when the card is pulled out, or when a fault flag is raised. It takes the steps in the reverse order, with a minimum gap between each step.

The regulator, the comparators, the thermal sensor and the pad drivers are outside the block. They appear here as fault flags at the inputs and as enables at the outputs. Two time bases come in as single-cycle strobes. The slow strobe paces every step and the start-up lockout. The card-clock strobe counts card clock periods for the reset hold-off. Every duration is a parameter counted in slow strobes. The defaults assume a 1.5 MHz slow strobe.

Top module: `scard_seq`

## Requirements
- R1: After reset, vcc_en, io_rx_en, clk_en and card_rst are 0, and off_n is 0 because no card has yet been seen.
- R2: A card counts as present when pres_hi is 1 or pres_lo_n is 0. A change of presence is accepted only after it has held for DEB_TICKS slow strobes, so shorter glitches are ignored.
- R3: A session request is refused during the first POR_TICKS slow strobes after reset, and during the same span after flt_vdd clears.
- R4: Only a 1-to-0 transition of cmd_n seen while idle starts a session. Holding cmd_n at 0 after a refused edge never starts one later.
- R5: A session starts only if a card is present and both flt_temp and flt_vdd are 0. Otherwise the request is dropped.
- R6: On start, vcc_en rises first. io_rx_en rises VCC_CHK_TICKS + IO_TICKS slow strobes later, and clk_en rises CLK_TICKS slow strobes after that. clk_en is never 1 while io_rx_en or vcc_en is 0.
- R7: If flt_vcc is 1 when the supply check ends, off_n goes low and vcc_en falls, and io_rx_en and clk_en never rise.
- R8: card_rst is 1 only while clk_en is 1. It copies rst_req only once RST_HOLD_CLKS card-clock strobes have passed since clk_en rose. An early request is held off until then.
- R9: When cmd_n returns to 1 during a session, the outputs go down in this order: card_rst, then clk_en after DN_CLK_TICKS, then io_rx_en, then vcc_en. Each step waits at least one slow strobe. Afterwards off_n again reports presence.
- R10: During a session, card removal or any of flt_vdd, flt_vpc, flt_vcc, flt_ocur, flt_temp drives off_n low on the next cycle and starts the same power-down. off_n stays low until cmd_n returns to 1.
- R11: Outside a session, the fault flags have no effect on off_n. off_n is then 1 with a card and 0 without one.
- R12: After a power-down with cmd_n still at 0, no new session starts until cmd_n goes to 1 and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow time-base strobe, one cycle wide |
| tick_card | input | 1 | One strobe per card clock period |
| cmd_n | input | 1 | Session command, active low, acts on its falling edge |
| rst_req | input | 1 | Host request for card reset |
| pres_hi | input | 1 | Presence switch, 1 means card present |
| pres_lo_n | input | 1 | Presence switch, 0 means card present |
| flt_vdd | input | 1 | Digital supply fault |
| flt_vpc | input | 1 | Regulator supply fault |
| flt_vcc | input | 1 | Card supply not valid |
| flt_ocur | input | 1 | Card over-current |
| flt_temp | input | 1 | Over-temperature |
| vcc_en | output | 1 | Card supply enable |
| io_rx_en | output | 1 | Card I/O lines in reception mode |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset line |
| off_n | output | 1 | Host interrupt, active low: no card outside a session, fault inside one |

## Verification
The assertions assume that tick_slow and tick_card are single-cycle strobes, and that every asynchronous input is seen only through the two-stage synchronizer. Under those assumptions, a rise of vcc_en can always be traced back to a synchronized command edge seen one cycle earlier. The stimulus changes inputs only on falling clock edges. It produces the strobes from a free-running counter, keeps each fault asserted for many slow strobes, and leaves cmd_n high for several cycles between sessions, so no fault pulse is shorter than the synchronizer can see. Durations are shrunk through parameters so that many full sessions fit in a short run.

// File: rtl/scard_pkg.sv
package scard_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_IOW,
        S_CLKW,
        S_ACT,
        S_DN_RST,
        S_DN_CLK,
        S_DN_IO,
        S_DN_VCC
    } seq_st_e;

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic st_powered(input seq_st_e s);
        return (s == S_PWR) || (s == S_IOW) || (s == S_CLKW) || (s == S_ACT);
    endfunction

    function automatic logic st_down(input seq_st_e s);
        return (s == S_DN_RST) || (s == S_DN_CLK) || (s == S_DN_IO) || (s == S_DN_VCC);
    endfunction

endpackage

// File: rtl/scard_sync.sv
module scard_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/scard_debounce.sv
module scard_debounce #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic stable
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= 1'b0;
        end else if (raw == st_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CW'(TICKS - 1)) begin
                st_q  <= raw;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stable = st_q;

    // R2: the accepted value moves only on a strobe, towards the raw level
    p_deb_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> ($past(tick) && ($past(raw) == st_q)));
endmodule

// File: rtl/scard_rst_gate.sv
module scard_rst_gate #(
    parameter int CLKS = 42000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(CLKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CW'(CLKS))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == CW'(CLKS));

    // R8: the hold-off window only reopens when the card clock is stopped
    p_hold_clr_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(clr));
endmodule

// File: rtl/scard_seq.sv
module scard_seq
    import scard_pkg::*;
#(
    parameter int POR_TICKS     = 15000,
    parameter int DEB_TICKS     = 4,
    parameter int VCC_CHK_TICKS = 765,
    parameter int IO_TICKS      = 3,
    parameter int CLK_TICKS     = 1,
    parameter int DN_RST_TICKS  = 1,
    parameter int DN_CLK_TICKS  = 12,
    parameter int DN_IO_TICKS   = 1,
    parameter int DN_VCC_TICKS  = 1,
    parameter int RST_HOLD_CLKS = 42000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_slow,
    input  logic tick_card,
    input  logic cmd_n,
    input  logic rst_req,
    input  logic pres_hi,
    input  logic pres_lo_n,
    input  logic flt_vdd,
    input  logic flt_vpc,
    input  logic flt_vcc,
    input  logic flt_ocur,
    input  logic flt_temp,
    output logic vcc_en,
    output logic io_rx_en,
    output logic clk_en,
    output logic card_rst,
    output logic off_n
);
    localparam int STEP_MAX = imax(imax(imax(VCC_CHK_TICKS, IO_TICKS), imax(CLK_TICKS, DN_RST_TICKS)),
                                   imax(imax(DN_CLK_TICKS, DN_IO_TICKS), DN_VCC_TICKS));
    localparam int SW    = $clog2(STEP_MAX + 1);
    localparam int PW    = $clog2(POR_TICKS + 1);
    localparam int NSYNC = 9;
    localparam logic [NSYNC-1:0] SYNC_INIT = 9'b1_0_0_1_0_0_0_0_0;

    // input synchronisation
    logic [NSYNC-1:0] raw_in, syn;
    logic cmd_s, rq_s, ph_s, pl_s, vdd_s, vpc_s, vcc_s, oc_s, tmp_s;

    assign raw_in = {cmd_n, rst_req, pres_hi, pres_lo_n, flt_vdd, flt_vpc, flt_vcc, flt_ocur, flt_temp};

    scard_sync #(.W(NSYNC), .INIT(SYNC_INIT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    assign {cmd_s, rq_s, ph_s, pl_s, vdd_s, vpc_s, vcc_s, oc_s, tmp_s} = syn;

    // card presence: either switch, debounced
    logic pres_raw, present;
    assign pres_raw = ph_s | ~pl_s;

    scard_debounce #(.TICKS(DEB_TICKS)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_slow),
        .raw    (pres_raw),
        .stable (present)
    );

    // command edge and start-up lockout
    logic          cmd_q, cmd_fall;
    logic [PW-1:0] por_cnt;
    logic          por_done;

    assign cmd_fall = cmd_q & ~cmd_s;
    assign por_done = (por_cnt == PW'(POR_TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= 1'b1;
            por_cnt <= '0;
        end else begin
            cmd_q <= cmd_s;
            if (vdd_s)
                por_cnt <= '0;
            else if (tick_slow && !por_done)
                por_cnt <= por_cnt + 1'b1;
        end
    end

    // sequencer state
    seq_st_e       st_q, st_d;
    logic [SW-1:0] step_cnt;
    logic          step_done;
    pins_t         pin_q, pin_d;
    logic          flt_q, flt_d;
    logic          hold_done, hold_clr;
    logic          vcc_bad, hard_flt, abort, stop;

    function automatic logic [SW-1:0] step_len(input seq_st_e s);
        case (s)
            S_PWR:    return SW'(VCC_CHK_TICKS);
            S_IOW:    return SW'(IO_TICKS);
            S_CLKW:   return SW'(CLK_TICKS);
            S_DN_RST: return SW'(DN_RST_TICKS);
            S_DN_CLK: return SW'(DN_CLK_TICKS);
            S_DN_IO:  return SW'(DN_IO_TICKS);
            S_DN_VCC: return SW'(DN_VCC_TICKS);
            default:  return '0;
        endcase
    endfunction

    assign step_done = (step_cnt == '0);
    assign hold_clr  = ~pin_q.clk;

    scard_rst_gate #(.CLKS(RST_HOLD_CLKS)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .clr  (hold_clr),
        .tick (tick_card),
        .done (hold_done)
    );

    always_comb begin
        vcc_bad  = vcc_s && ((st_q == S_IOW) || (st_q == S_CLKW) || (st_q == S_ACT) ||
                             ((st_q == S_PWR) && step_done));
        hard_flt = vdd_s | vpc_s | oc_s | tmp_s | ~present;
        abort    = st_powered(st_q) && (hard_flt || vcc_bad);
        stop     = st_powered(st_q) && cmd_s;

        st_d = st_q;
        case (st_q)
            S_IDLE:   if (cmd_fall && por_done && present && !tmp_s && !vdd_s) st_d = S_PWR;
            S_PWR:    if (step_done) st_d = S_IOW;
            S_IOW:    if (step_done) st_d = S_CLKW;
            S_CLKW:   if (step_done) st_d = S_ACT;
            S_DN_RST: if (step_done) st_d = S_DN_CLK;
            S_DN_CLK: if (step_done) st_d = S_DN_IO;
            S_DN_IO:  if (step_done) st_d = S_DN_VCC;
            S_DN_VCC: if (step_done) st_d = S_IDLE;
            default:  st_d = st_q;
        endcase
        if (abort || stop)
            st_d = S_DN_RST;

        // enables only rise in their own step and only fall in their own step
        pin_d.vcc = st_powered(st_d) || (st_down(st_d) && pin_q.vcc);
        pin_d.io  = (st_d == S_CLKW) || (st_d == S_ACT) ||
                    (((st_d == S_DN_RST) || (st_d == S_DN_CLK) || (st_d == S_DN_IO)) && pin_q.io);
        pin_d.clk = (st_d == S_ACT) ||
                    (((st_d == S_DN_RST) || (st_d == S_DN_CLK)) && pin_q.clk);
        pin_d.rst = ((st_d == S_ACT) && rq_s && hold_done) ||
                    ((st_d == S_DN_RST) && pin_q.rst);

        flt_d = abort || (flt_q && !((st_q == S_IDLE) && cmd_s));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            step_cnt <= '0;
            pin_q    <= '0;
            flt_q    <= 1'b0;
        end else begin
            st_q  <= st_d;
            pin_q <= pin_d;
            flt_q <= flt_d;
            if (st_d != st_q)
                step_cnt <= step_len(st_d);
            else if (tick_slow && !step_done)
                step_cnt <= step_cnt - 1'b1;
        end
    end

    assign vcc_en   = pin_q.vcc;
    assign io_rx_en = pin_q.io;
    assign clk_en   = pin_q.clk;
    assign card_rst = pin_q.rst;
    assign off_n    = ~flt_q & ((st_q != S_IDLE) | present);

    // R6: the card clock only runs on a powered card with I/O in reception
    p_clk_powered_r6: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> (io_rx_en && vcc_en));

    // R8: card reset never before the hold-off has expired
    p_rst_hold_r8: assert property (@(posedge clk) disable iff (rst)
        card_rst |-> (hold_done && clk_en));

    // R4: power-up is caused by a command edge
    p_start_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(vcc_en) |-> $past(cmd_fall));

    // R3: no power-up inside the lockout window
    p_start_por_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(vcc_en) |-> $past(por_done));

    // R5: power-up needs a card and no blocking fault
    p_start_cond_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(vcc_en) |-> $past(present && !tmp_s && !vdd_s));

    // R10: a fault in a session reaches the host on the next cycle
    p_abort_off_r10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !off_n);

    // R9: the supply is the last output to go
    p_vcc_last_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(vcc_en) |-> (!io_rx_en && !clk_en && !card_rst));

    // R9: I/O leaves reception only with the clock already stopped
    p_io_after_clk_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(io_rx_en) |-> !clk_en);
endmodule

// File: tb/scard_seq_tb.sv
module scard_seq_tb_top;
    localparam int TP       = 4;   // cycles per slow strobe
    localparam int CP       = 2;   // cycles per card-clock strobe
    localparam int POR_T    = 20;
    localparam int DEB_T    = 2;
    localparam int CHK_T    = 6;
    localparam int IO_T     = 2;
    localparam int CLK_T    = 1;
    localparam int DNR_T    = 1;
    localparam int DNC_T    = 4;
    localparam int DNI_T    = 1;
    localparam int DNV_T    = 1;
    localparam int HOLD_C   = 40;
    localparam int DEBW     = (DEB_T + 2) * TP + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_slow = 1'b0, tick_card = 1'b0;
    logic cmd_n = 1'b1, rst_req = 1'b0, pres_hi = 1'b0, pres_lo_n = 1'b1;
    logic flt_vdd = 1'b0, flt_vpc = 1'b0, flt_vcc = 1'b0, flt_ocur = 1'b0, flt_temp = 1'b0;
    logic vcc_en, io_rx_en, clk_en, card_rst, off_n;

    int checks = 0, errors = 0, cyc = 0, tdiv = 0;
    bit finished = 1'b0;
    int t_vcc_r, t_io_r, t_clk_r, t_rst_r, t_rst_f, t_clk_f, t_io_f, t_vcc_f, t_cmd;
    logic p_vcc = 1'b0, p_io = 1'b0, p_clk = 1'b0, p_rst = 1'b0;

    always #4 clk = ~clk;

    scard_seq #(
        .POR_TICKS(POR_T), .DEB_TICKS(DEB_T), .VCC_CHK_TICKS(CHK_T), .IO_TICKS(IO_T),
        .CLK_TICKS(CLK_T), .DN_RST_TICKS(DNR_T), .DN_CLK_TICKS(DNC_T), .DN_IO_TICKS(DNI_T),
        .DN_VCC_TICKS(DNV_T), .RST_HOLD_CLKS(HOLD_C)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_card(tick_card),
        .cmd_n(cmd_n), .rst_req(rst_req), .pres_hi(pres_hi), .pres_lo_n(pres_lo_n),
        .flt_vdd(flt_vdd), .flt_vpc(flt_vpc), .flt_vcc(flt_vcc), .flt_ocur(flt_ocur),
        .flt_temp(flt_temp), .vcc_en(vcc_en), .io_rx_en(io_rx_en), .clk_en(clk_en),
        .card_rst(card_rst), .off_n(off_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic chk_rng(input int v, input int lo, input int hi, input string req);
        chk((v >= lo) && (v <= hi), req, v, lo);
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_times();
        t_vcc_r = -1; t_io_r = -1; t_clk_r = -1; t_rst_r = -1;
        t_rst_f = -1; t_clk_f = -1; t_io_f = -1; t_vcc_f = -1;
    endtask

    task automatic open_session();
        clr_times();
        cmd_n = 1'b1;
        wcyc(6);
        t_cmd = cyc;
        cmd_n = 1'b0;
        wcyc(70);
    endtask

    task automatic check_down_order(input string req);
        if (t_clk_f >= 0) begin
            chk(t_io_f > t_clk_f, req, t_io_f, t_clk_f + 1);
        end
        if (t_io_f >= 0) begin
            chk(t_vcc_f > t_io_f, req, t_vcc_f, t_io_f + 1);
        end
        chk(vcc_en == 1'b0, req, vcc_en, 0);
    endtask

    function automatic bit exp_off(input int kind);
        return (kind == 0);   // host close leaves a present card reported, faults pull low
    endfunction

    // time bases and output monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tdiv++;
            tick_slow = ((tdiv % TP) == 0);
            tick_card = ((tdiv % CP) == 0);
            if (!rst) begin
                if (vcc_en && !p_vcc)   t_vcc_r = cyc;
                if (!vcc_en && p_vcc)   t_vcc_f = cyc;
                if (io_rx_en && !p_io)  t_io_r = cyc;
                if (!io_rx_en && p_io)  t_io_f = cyc;
                if (clk_en && !p_clk)   t_clk_r = cyc;
                if (!clk_en && p_clk)   t_clk_f = cyc;
                if (card_rst && !p_rst) t_rst_r = cyc;
                if (!card_rst && p_rst) t_rst_f = cyc;
                if (clk_en && !(vcc_en && io_rx_en)) chk(1'b0, "R6 clock without power", clk_en, 0);
                if (card_rst && !clk_en)             chk(1'b0, "R8 reset without clock", card_rst, 0);
            end
            p_vcc = vcc_en; p_io = io_rx_en; p_clk = clk_en; p_rst = card_rst;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7301);
        clr_times();
        wcyc(5);
        rst = 1'b0;
        wcyc(2);
        // R1 reset state
        chk({vcc_en, io_rx_en, clk_en, card_rst, off_n} == 5'b0, "R1",
            {vcc_en, io_rx_en, clk_en, card_rst, off_n}, 0);

        // R3 / R4: request inside lockout is refused, held level does not start later
        pres_hi = 1'b1;
        wcyc(28);
        cmd_n = 1'b0;
        wcyc(100);
        chk(t_vcc_r == -1, "R3 lockout", t_vcc_r, -1);
        chk(vcc_en == 1'b0, "R4 level held low", vcc_en, 0);

        // R6 / R3: normal session after lockout
        open_session();
        chk(clk_en == 1'b1, "R3 start after lockout", clk_en, 1);
        chk_rng(t_vcc_r - t_cmd, 1, 8, "R6 supply first");
        chk_rng(t_io_r - t_vcc_r, (CHK_T + IO_T - 1) * TP, (CHK_T + IO_T + 1) * TP + 8, "R6 io gap");
        chk_rng(t_clk_r - t_io_r, 1, (CLK_T + 1) * TP + 8, "R6 clk gap");
        wcyc(HOLD_C * CP + 20);
        chk(card_rst == 1'b0, "R8 no request", card_rst, 0);
        rst_req = 1'b1;
        wcyc(6);
        chk(card_rst == 1'b1, "R8 follow high", card_rst, 1);
        rst_req = 1'b0;
        wcyc(6);
        chk(card_rst == 1'b0, "R8 follow low", card_rst, 0);
        rst_req = 1'b1;
        wcyc(6);
        // R9 host close
        t_cmd = cyc;
        cmd_n = 1'b1;
        wcyc(70);
        chk_rng(t_rst_f - t_cmd, 1, 16, "R9 reset first");
        chk_rng(t_clk_f - t_rst_f, (DNC_T - 1) * TP, (DNC_T + 1) * TP + 8, "R9 clk gap");
        chk_rng(t_io_f - t_clk_f, 1, 16, "R9 io gap");
        chk_rng(t_vcc_f - t_io_f, 1, 16, "R9 vcc gap");
        chk(off_n == 1'b1, "R9 presence after close", off_n, 1);

        // R8 early request held off; R10 over-current abort
        open_session();
        wcyc(HOLD_C * CP + 20);
        chk_rng(t_rst_r - t_clk_r, HOLD_C * CP - 4, HOLD_C * CP + 20, "R8 hold-off");
        flt_ocur = 1'b1;
        wcyc(4);
        chk(off_n == 1'b0, "R10 fault report", off_n, 1'b0);
        wcyc(70);
        check_down_order("R10 order");
        flt_ocur = 1'b0;
        rst_req = 1'b0;
        wcyc(40);
        chk(off_n == 1'b0, "R10 held while cmd low", off_n, 0);
        chk(vcc_en == 1'b0, "R12 no restart", vcc_en, 0);
        cmd_n = 1'b1;
        wcyc(8);
        chk(off_n == 1'b1, "R10 cleared by cmd high", off_n, 1);
        // R11 faults outside a session
        flt_ocur = 1'b1; flt_vpc = 1'b1;
        wcyc(12);
        chk(off_n == 1'b1, "R11 faults ignored", off_n, 1);
        flt_ocur = 1'b0; flt_vpc = 1'b0;

        // R12 restart after fault needs new edge
        open_session();
        chk(clk_en == 1'b1, "R12 restart on new edge", clk_en, 1);
        cmd_n = 1'b1;
        wcyc(40);

        // R7 card supply check fails
        flt_vcc = 1'b1;
        open_session();
        chk(t_io_r == -1 && t_clk_r == -1, "R7 io/clk never on", t_io_r, -1);
        chk(t_vcc_r >= 0 && vcc_en == 1'b0, "R7 supply off", vcc_en, 0);
        chk(off_n == 1'b0, "R7 report", off_n, 0);
        cmd_n = 1'b1;
        flt_vcc = 1'b0;
        wcyc(8);

        // R5 blocked by temperature, then by missing card
        flt_temp = 1'b1;
        open_session();
        chk(t_vcc_r == -1, "R5 temp blocks", t_vcc_r, -1);
        cmd_n = 1'b1;
        flt_temp = 1'b0;
        pres_hi = 1'b0;
        wcyc(DEBW);
        chk(off_n == 1'b0, "R11 no card reported", off_n, 0);
        open_session();
        chk(t_vcc_r == -1, "R5 no card blocks", t_vcc_r, -1);
        cmd_n = 1'b1;

        // R2 presence polarities and glitch rejection
        pres_lo_n = 1'b0;
        wcyc(DEBW);
        chk(off_n == 1'b1, "R2 low-active switch", off_n, 1);
        pres_lo_n = 1'b1;
        wcyc(DEBW);
        chk(off_n == 1'b0, "R2 removal", off_n, 0);
        pres_hi = 1'b1;
        wcyc(DEBW);
        chk(off_n == 1'b1, "R2 high-active switch", off_n, 1);
        pres_hi = 1'b0;
        wcyc(2);
        pres_hi = 1'b1;
        wcyc(DEBW);
        chk(off_n == 1'b1, "R2 glitch ignored", off_n, 1);

        // R3 lockout restarts after digital supply fault
        flt_vdd = 1'b1;
        wcyc(10);
        flt_vdd = 1'b0;
        wcyc(4);
        open_session();
        chk(t_vcc_r == -1, "R3 lockout after supply fault", t_vcc_r, -1);
        cmd_n = 1'b1;
        wcyc(POR_T * TP + 10);
        open_session();
        chk(clk_en == 1'b1, "R3 start after supply lockout", clk_en, 1);

        // R10 removal in session
        pres_hi = 1'b0;
        wcyc(DEBW + 4);
        chk(off_n == 1'b0, "R10 removal report", off_n, 0);
        wcyc(60);
        check_down_order("R10 removal order");
        cmd_n = 1'b1;
        pres_hi = 1'b1;
        wcyc(DEBW);

        // random sessions with mixed closing causes
        for (int it = 0; it < 10; it++) begin
            int kind;
            int hold;
            kind = int'($urandom % 4);
            hold = 20 + int'($urandom % 150);
            rst_req = 1'($urandom % 2);
            open_session();
            chk(clk_en == 1'b1, "R6 random start", clk_en, 1);
            wcyc(hold);
            case (kind)
                0: cmd_n = 1'b1;
                1: flt_ocur = 1'b1;
                2: flt_vpc = 1'b1;
                default: flt_temp = 1'b1;
            endcase
            wcyc(70);
            check_down_order(kind == 0 ? "R9 random order" : "R10 random order");
            chk(off_n == exp_off(kind), "R10 random report", off_n, exp_off(kind));
            flt_ocur = 1'b0; flt_vpc = 1'b0; flt_temp = 1'b0;
            cmd_n = 1'b1;
            wcyc(12);
            chk(off_n == 1'b1, "R11 random idle report", off_n, 1);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule